// File: doc/BRIEF.md
# Lock Elision Nesting Controller

This block follows speculative lock-elision regions on a single hardware thread. Acquire and release events come in on one shared bus, and each event carries a lock address, lock data and an instruction pointer. The block keeps a nest counter and a small buffer of elided locks, and it holds an active flag. When the outermost acquire arrives, it saves the instruction pointer as the restart point.

At the end of the region the block either asks an external agent to commit, or it aborts. An abort reports the saved restart pointer and raises a flag so that the next instruction runs with its hint ignored. The surrounding core restores registers and discards speculative memory writes. This block only signals when those actions are needed. Conflict detection also lives outside, and it reaches the block through an external abort input.

The controller has three states:
- `ST_IDLE`: no region is open.
- `ST_SPEC`: a region is open, with a nest count from 1 to the maximum.
- `ST_COMMIT`: the block is waiting on the commit response.

It has these transitions:
- `T_OPEN`: IDLE to SPEC, on an outermost acquire.
- `T_NEST`: SPEC to SPEC, on an inner acquire or a non-final release.
- `T_DRAIN`: SPEC to COMMIT, on a final release with an empty buffer.
- `T_DONE`: COMMIT to IDLE, on a successful response.
- `T_ABORT`: SPEC or COMMIT to IDLE, on any abort cause.
- `T_SKIP`: the first event after an abort is consumed and has no other effect.

Top module: `elide_nest_ctrl`

## Requirements
- R1: After reset, `active`, `ckpt_req`, `abort_pulse`, `commit_req` and `ignore_hint` are all 0.
- R2: An acquire arriving with the count at 0 sets `active` and raises `ckpt_req` for exactly one cycle, starting the cycle after the event.
- R3: An acquire below `MAX_NEST` increments the count without a checkpoint. An acquire arriving with the count equal to `MAX_NEST` aborts.
- R4: The restart pointer is captured only on the outermost acquire. If `long_mode` is 1 it holds the full `ev_ip`; if `long_mode` is 0 it holds `ev_ip[31:0]` with the upper bits zero.
- R5: An acquire takes a free buffer entry for its address and data. If the buffer is full, the region proceeds without elision, and a later release of that unbuffered address never aborts on its data.
- R6: A release whose address matches a buffered entry frees that entry when the data is equal, and aborts when the data differs.
- R7: A release that brings the count to 0 while any buffer entry remains allocated aborts.
- R8: A release that brings the count to 0 with an empty buffer raises `commit_req` and holds it until `commit_ack`. If `commit_ok` is 1, `active` falls with no abort; if `commit_ok` is 0, the block aborts.
- R9: An abort gives a one-cycle `abort_pulse`, clears `active` and the count, frees every buffer entry, and sets `ignore_hint`.
- R10: While `ignore_hint` is 1, the next acquire or release is consumed without effect on the region and clears `ignore_hint`.
- R11: A release arriving with the count at 0 changes no state.
- R12: `ext_abort` while a region is open aborts, even when an acquire or release arrives in the same cycle. `ext_abort` with no region open has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acq_valid | input | 1 | Acquire event this cycle |
| rel_valid | input | 1 | Release event this cycle |
| ev_addr | input | ADDR_W | Lock address of the event |
| ev_data | input | DATA_W | Lock data of the event |
| ev_ip | input | IP_W | Instruction pointer of the event |
| long_mode | input | 1 | 1 selects the full-width pointer, 0 selects the low 32 bits |
| ext_abort | input | 1 | Abort request from conflict tracking |
| commit_ack | input | 1 | Commit response valid |
| commit_ok | input | 1 | Commit response: 1 for success, 0 for failure |
| ckpt_req | output | 1 | One-cycle request to checkpoint register state |
| commit_req | output | 1 | Commit request, held until acknowledged |
| abort_pulse | output | 1 | One-cycle abort indication |
| restart_ip | output | IP_W | Saved restart pointer |
| ignore_hint | output | 1 | The next instruction runs with its hint ignored |
| active | output | 1 | A region is open or committing |

## Verification
The assertions assume that `acq_valid` and `rel_valid` are never high in the same cycle. They also assume that `commit_ack` arrives only while `commit_req` is high. The stimulus keeps to both rules: it presents at most one event per cycle and pulses the response only after the request has been seen. Consecutive abort pulses cannot occur under these rules, because an abort closes the region and `ext_abort` with no region open does nothing. The stimulus drives the shared event bus half a cycle before the edge that takes it in, and it samples the registered outputs just after that edge.

// File: rtl/elide_pkg.sv
package elide_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SPEC   = 2'd1,
        ST_COMMIT = 2'd2
    } nest_state_e;
endpackage

// File: rtl/elide_buf.sv
// Elided-lock buffer: allocation, release lookup and bulk clear.
module elide_buf #(
    parameter int ENTRIES = 2,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_en,
    input  logic              free_en,
    input  logic              clear_all,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              full,
    output logic              hit,
    output logic              data_ok,
    output logic              left_after_free
);
    logic [ENTRIES-1:0] vld_q;
    logic [ADDR_W-1:0]  addr_q [ENTRIES];
    logic [DATA_W-1:0]  data_q [ENTRIES];
    logic [ENTRIES-1:0] hit_sel;
    logic [ENTRIES-1:0] free_sel;

    // Pick the lowest matching entry and the lowest free entry.
    always_comb begin
        logic got_hit;
        logic got_free;
        got_hit  = 1'b0;
        got_free = 1'b0;
        hit_sel  = '0;
        free_sel = '0;
        data_ok  = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!got_hit && vld_q[i] && addr_q[i] == addr) begin
                got_hit    = 1'b1;
                hit_sel[i] = 1'b1;
                data_ok    = (data_q[i] == data);
            end
            if (!got_free && !vld_q[i]) begin
                got_free    = 1'b1;
                free_sel[i] = 1'b1;
            end
        end
    end

    assign full            = &vld_q;
    assign hit             = |hit_sel;
    assign left_after_free = |(vld_q & ~hit_sel);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q[g] <= 1'b0;
            end else if (clear_all) begin
                vld_q[g] <= 1'b0;
            end else if (alloc_en && free_sel[g]) begin
                vld_q[g] <= 1'b1;
            end else if (free_en && hit_sel[g]) begin
                vld_q[g] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (alloc_en && free_sel[g]) begin
                addr_q[g] <= addr;
                data_q[g] <= data;
            end
        end
    end
endmodule

// File: rtl/elide_rip.sv
// Restart pointer capture with mode-dependent width.
module elide_rip #(
    parameter int IP_W     = 64,
    parameter int NARROW_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic            long_mode,
    input  logic [IP_W-1:0] ip_in,
    output logic [IP_W-1:0] rip
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rip <= '0;
        end else if (capture) begin
            rip <= long_mode ? ip_in : IP_W'(ip_in[NARROW_W-1:0]);
        end
    end
endmodule

// File: rtl/elide_nest_ctrl.sv
module elide_nest_ctrl
    import elide_pkg::*;
#(
    parameter int MAX_NEST    = 4,
    parameter int BUF_ENTRIES = 2,
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int IP_W        = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acq_valid,
    input  logic              rel_valid,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [DATA_W-1:0] ev_data,
    input  logic [IP_W-1:0]   ev_ip,
    input  logic              long_mode,
    input  logic              ext_abort,
    input  logic              commit_ack,
    input  logic              commit_ok,
    output logic              ckpt_req,
    output logic              commit_req,
    output logic              abort_pulse,
    output logic [IP_W-1:0]   restart_ip,
    output logic              ignore_hint,
    output logic              active
);
    localparam int CNT_W = $clog2(MAX_NEST + 1);

    nest_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             ign_q, ign_d;

    logic abort_now, ckpt_now, capture, alloc_en, free_en;
    logic buf_full, buf_hit, buf_data_ok, buf_left;

    // Next-state and transition decisions.
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        ign_d     = ign_q;
        abort_now = 1'b0;
        ckpt_now  = 1'b0;
        capture   = 1'b0;
        alloc_en  = 1'b0;
        free_en   = 1'b0;
        if (state_q != ST_IDLE && ext_abort) begin
            abort_now = 1'b1;                          // T_ABORT (external)
        end else if (ign_q && (acq_valid || rel_valid)) begin
            ign_d = 1'b0;                              // T_SKIP
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (acq_valid) begin               // T_OPEN
                        state_d  = ST_SPEC;
                        cnt_d    = CNT_W'(1);
                        capture  = 1'b1;
                        ckpt_now = 1'b1;
                        alloc_en = !buf_full;
                    end
                end
                ST_SPEC: begin
                    if (acq_valid) begin
                        if (cnt_q == CNT_W'(MAX_NEST)) begin
                            abort_now = 1'b1;          // T_ABORT (depth)
                        end else begin                 // T_NEST
                            cnt_d    = cnt_q + CNT_W'(1);
                            alloc_en = !buf_full;
                        end
                    end else if (rel_valid) begin
                        cnt_d = cnt_q - CNT_W'(1);
                        if (buf_hit && !buf_data_ok) begin
                            abort_now = 1'b1;          // T_ABORT (value)
                        end else begin
                            free_en = buf_hit;
                            if (cnt_q == CNT_W'(1)) begin
                                if (buf_left) abort_now = 1'b1;  // T_ABORT (leftover)
                                else          state_d   = ST_COMMIT; // T_DRAIN
                            end
                        end
                    end
                end
                ST_COMMIT: begin
                    if (commit_ack) begin
                        if (commit_ok) state_d   = ST_IDLE;  // T_DONE
                        else           abort_now = 1'b1;     // T_ABORT (commit)
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
        if (abort_now) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
            ign_d   = 1'b1;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            ign_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            ign_q   <= ign_d;
        end
    end

    // Registered outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ckpt_req    <= 1'b0;
            abort_pulse <= 1'b0;
            commit_req  <= 1'b0;
            active      <= 1'b0;
        end else begin
            ckpt_req    <= ckpt_now;
            abort_pulse <= abort_now;
            commit_req  <= (state_d == ST_COMMIT);
            active      <= (state_d != ST_IDLE);
        end
    end

    assign ignore_hint = ign_q;

    elide_buf #(
        .ENTRIES(BUF_ENTRIES),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_buf (
        .clk            (clk),
        .rst_n          (rst_n),
        .alloc_en       (alloc_en),
        .free_en        (free_en),
        .clear_all      (abort_now),
        .addr           (ev_addr),
        .data           (ev_data),
        .full           (buf_full),
        .hit            (buf_hit),
        .data_ok        (buf_data_ok),
        .left_after_free(buf_left)
    );

    elide_rip #(
        .IP_W    (IP_W),
        .NARROW_W(32)
    ) u_rip (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .long_mode(long_mode),
        .ip_in    (ev_ip),
        .rip      (restart_ip)
    );
endmodule

// File: rtl/elide_nest_chk.sv
module elide_nest_chk #(
    parameter int IP_W = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ckpt_req,
    input logic            abort_pulse,
    input logic            commit_req,
    input logic            commit_ack,
    input logic            active,
    input logic            ignore_hint,
    input logic [IP_W-1:0] restart_ip
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!active && !ckpt_req && !abort_pulse && !commit_req));

    p_ckpt_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_req |=> !ckpt_req);

    p_ckpt_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_req |-> active);

    p_rip_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(active) && active) |-> $stable(restart_ip));

    p_creq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_req && !commit_ack) |=> commit_req);

    p_abort_effects_r9: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> (!active && ignore_hint && !commit_req));

    p_abort_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |=> !abort_pulse);
endmodule

bind elide_nest_ctrl elide_nest_chk #(.IP_W(IP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ckpt_req   (ckpt_req),
    .abort_pulse(abort_pulse),
    .commit_req (commit_req),
    .commit_ack (commit_ack),
    .active     (active),
    .ignore_hint(ignore_hint),
    .restart_ip (restart_ip)
);

// File: tb/sim_elide_nest_ctrl.sv
`timescale 1ns/1ps
module sim_elide_nest_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acq_valid = 1'b0, rel_valid = 1'b0, ext_abort = 1'b0;
    logic        commit_ack = 1'b0, commit_ok = 1'b0, long_mode = 1'b1;
    logic [31:0] ev_addr = '0, ev_data = '0;
    logic [63:0] ev_ip = '0;
    logic        ckpt_req, commit_req, abort_pulse, ignore_hint, active;
    logic [63:0] restart_ip;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    elide_nest_ctrl #(.MAX_NEST(4), .BUF_ENTRIES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .acq_valid(acq_valid), .rel_valid(rel_valid),
        .ev_addr(ev_addr), .ev_data(ev_data), .ev_ip(ev_ip), .long_mode(long_mode),
        .ext_abort(ext_abort), .commit_ack(commit_ack), .commit_ok(commit_ok),
        .ckpt_req(ckpt_req), .commit_req(commit_req), .abort_pulse(abort_pulse),
        .restart_ip(restart_ip), .ignore_hint(ignore_hint), .active(active)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle with the given inputs; returns just after the capturing edge.
    task automatic step(input logic a, input logic r, input logic x,
                        input logic [31:0] ad, input logic [31:0] dt,
                        input logic [63:0] ip, input logic lm);
        @(negedge clk);
        acq_valid = a; rel_valid = r; ext_abort = x;
        ev_addr = ad; ev_data = dt; ev_ip = ip; long_mode = lm;
        @(posedge clk);
        #1;
        acq_valid = 1'b0; rel_valid = 1'b0; ext_abort = 1'b0;
    endtask

    task automatic respond(input logic ok);
        @(negedge clk);
        commit_ack = 1'b1; commit_ok = ok;
        @(posedge clk);
        #1;
        commit_ack = 1'b0;
    endtask

    typedef struct packed {
        logic        a;
        logic        r;
        logic [31:0] ad;
        logic [31:0] dt;
        logic [3:0]  ex;   // {active, ckpt_req, abort_pulse, commit_req}
    } vec_t;

    localparam vec_t TBL [6] = '{
        '{1'b1, 1'b0, 32'h10, 32'h11, 4'b1100},  // R2 outermost acquire
        '{1'b1, 1'b0, 32'h20, 32'h22, 4'b1000},  // R3 nested
        '{1'b1, 1'b0, 32'h30, 32'h33, 4'b1000},  // R5 buffer full
        '{1'b0, 1'b1, 32'h30, 32'h99, 4'b1000},  // R5 unbuffered release
        '{1'b0, 1'b1, 32'h20, 32'h22, 4'b1000},  // R6 matching data
        '{1'b0, 1'b1, 32'h10, 32'h11, 4'b1001}   // R8 drain to commit
    };

    localparam logic [63:0] IP_A = 64'hFFFF_FFFF_1234_5678;
    localparam logic [63:0] IP_B = 64'hA000_0000_0000_0100;
    localparam logic [63:0] IP_T = 64'h0000_7F00_0000_0040;

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 active", active, 0);
        check("R1 ckpt", ckpt_req, 0);
        check("R1 abort", abort_pulse, 0);
        check("R1 creq", commit_req, 0);
        check("R1 ignore", ignore_hint, 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < 6; i++) begin
            step(TBL[i].a, TBL[i].r, 1'b0, TBL[i].ad, TBL[i].dt, IP_T + 64'(i * 4), 1'b1);
            check($sformatf("table row %0d (R2/R3/R5/R6/R8)", i),
                  {active, ckpt_req, abort_pulse, commit_req}, TBL[i].ex);
        end
        check("R4 restart full width", restart_ip, IP_T);

        // R8 commit success
        step(0, 0, 0, 0, 0, 0, 1);
        check("R8 creq held", commit_req, 1);
        respond(1'b1);
        check("R8 ok active", active, 0);
        check("R8 ok creq", commit_req, 0);
        check("R8 ok abort", abort_pulse, 0);

        // R4 narrow mode, R6 mismatch abort
        step(1, 0, 0, 32'h40, 32'h44, IP_A, 0);
        check("R4 narrow restart", restart_ip, 64'h0000_0000_1234_5678);
        check("R2 ckpt", ckpt_req, 1);
        step(0, 1, 0, 32'h40, 32'h45, IP_B, 1);
        check("R6 abort", abort_pulse, 1);
        check("R2 ckpt low", ckpt_req, 0);
        check("R9 active", active, 0);
        check("R9 ignore", ignore_hint, 1);
        check("R9 restart", restart_ip, 64'h0000_0000_1234_5678);

        // R10 first event consumed
        step(1, 0, 0, 32'h50, 32'h55, IP_B, 1);
        check("R9 abort one cycle", abort_pulse, 0);
        check("R10 no open", active, 0);
        check("R10 no ckpt", ckpt_req, 0);
        check("R10 cleared", ignore_hint, 0);

        // R11 release at zero
        step(0, 1, 0, 32'h50, 32'h55, IP_B, 1);
        check("R11 active", {active, abort_pulse, commit_req}, 0);
        step(1, 0, 0, 32'h58, 32'h1, IP_B, 1);
        check("R11 count still zero ckpt", ckpt_req, 1);
        check("R4 full restart", restart_ip, IP_B);

        // R3 depth limit
        step(1, 0, 0, 32'h60, 32'h2, IP_A, 1);
        step(1, 0, 0, 32'h70, 32'h3, IP_A, 1);
        step(1, 0, 0, 32'h80, 32'h4, IP_A, 1);
        check("R3 at max no abort", {active, ckpt_req, abort_pulse}, 3'b100);
        check("R4 inner no capture", restart_ip, IP_B);
        step(1, 0, 0, 32'h90, 32'h5, IP_A, 1);
        check("R3 over max abort", abort_pulse, 1);
        check("R3 over max active", active, 0);
        step(0, 1, 0, 0, 0, 0, 1);                 // consume hint
        check("R10 release consumed", ignore_hint, 0);

        // R7 leftover entries
        step(1, 0, 0, 32'h10, 32'h1, IP_T, 1);
        step(1, 0, 0, 32'h20, 32'h2, IP_T, 1);
        step(0, 1, 0, 32'h33, 32'h3, IP_T, 1);
        check("R7 partial", {active, abort_pulse}, 2'b10);
        step(0, 1, 0, 32'h34, 32'h4, IP_T, 1);
        check("R7 leftover abort", abort_pulse, 1);
        check("R7 creq", commit_req, 0);
        step(1, 0, 0, 0, 0, 0, 1);                 // consume hint

        // R8 commit failure; R9 buffer freed so a fresh region commits cleanly
        step(1, 0, 0, 32'h10, 32'h7, IP_T, 1);
        step(0, 1, 0, 32'h10, 32'h7, IP_T, 1);
        check("R9 buffer freed", commit_req, 1);
        respond(1'b0);
        check("R8 fail abort", abort_pulse, 1);
        check("R8 fail active", {active, commit_req}, 2'b00);
        step(1, 0, 0, 0, 0, 0, 1);                 // consume hint

        // R12 external abort priority
        step(1, 0, 0, 32'h10, 32'h7, IP_T, 1);
        step(1, 0, 1, 32'h20, 32'h8, IP_A, 1);
        check("R12 ext abort wins", abort_pulse, 1);
        check("R12 active", active, 0);
        check("R12 ignore", ignore_hint, 1);
        step(0, 1, 0, 0, 0, 0, 1);                 // consume hint
        step(0, 0, 1, 0, 0, 0, 1);
        check("R12 idle no effect", {abort_pulse, active, ignore_hint}, 3'b000);

        repeat (2) @(posedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule